// File: doc/BRIEF.md
# Multi-Policy Cache Victim Selector

This block keeps the replacement history for every set of a four-way set-associative cache. When the cache misses, the block names the way that should be evicted. The cache controller reports each hit or fill to the block as an access: a set index, a way number and a strobe that tells a fill from a hit. When a line must be refilled, the controller raises a replacement request for a set. One cycle later the block returns the victim way.

A three-bit select picks one of five policies:

- exact use-bit LRU over ways 0 and 1;
- four-way tree pseudo-LRU;
- FIFO in fill order;
- least-frequently-used, built on saturating reference counts;
- random, driven by a free-running LFSR.

The state for all five policies is updated on every access, whichever policy is selected. Switching the select therefore takes effect at once and uses the history already gathered. The set index is taken from the low-order bits of the block address, because the set is the block number modulo the set count.

The output side is a two-state machine. CTRL_IDLE moves to CTRL_REPORT when a request is sampled. CTRL_REPORT stays in CTRL_REPORT when another request arrives, and returns to CTRL_IDLE when none does. The victim is valid exactly while the machine is in CTRL_REPORT.

Top module: `victim_selector`

## Requirements
- R1: A request sampled on a clock edge makes `victim_valid` high after that edge, with `victim_way` holding the victim. `victim_valid` is low after any edge on which no request was sampled.
- R2: `policy_sel` encodings: 0 is two-way LRU, 1 is tree pseudo-LRU, 2 is FIFO, 3 is LFU, 4 is random. Codes 5 to 7 always return way 0.
- R3: Two-way LRU keeps one use bit per line for ways 0 and 1. An access to way 0 or way 1 sets that line's bit and clears the other line's bit. The victim is way 0 when its bit is 0, otherwise way 1. Accesses to ways 2 and 3 leave these bits unchanged.
- R4: Tree pseudo-LRU keeps a root bit naming the less recently used pair, where pair 0 is ways 0 and 1 and pair 1 is ways 2 and 3. It also keeps one bit per pair naming the less recently used way inside it. An access to way w points the root at the other pair and points w's pair bit at w's partner. The victim is the way that the pair bit names inside the pair that the root names.
- R5: FIFO keeps a two-bit pointer per set. Every fill advances the pointer by one, wrapping from 3 to 0, whichever way was filled. Hits do not move it. The victim is the pointer value.
- R6: LFU keeps a three-bit count per line. A hit adds one and saturates at 7. A fill sets the filled line's count to 1. The victim is the way with the smallest count, and ties go to the lowest-numbered way.
- R7: Random mode returns bits [1:0] of a 16-bit LFSR. The LFSR loads 16'hACE1 in reset and then shifts left on every clock, taking bit15^bit13^bit12^bit10 into bit 0. The value it holds at the sampling edge is the one used.
- R8: A synchronous reset clears every use bit, tree bit, FIFO pointer and LFU count, so the first victim of every set is way 0 in policies 0 to 3. Reset also drives `victim_valid` low.
- R9: When an access and a request name the same set in the same cycle, the victim is computed from the state after that access.
- R10: Each set keeps its own state. An access to one set never changes the victim of another set, even when both fall in the same cycle.
- R11: The state of every policy is kept up to date under all selects, so a policy chosen later returns the victim implied by all earlier accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policy_sel | input | 3 | Replacement policy code |
| acc_valid | input | 1 | Access strobe (hit or fill) |
| acc_fill | input | 1 | 1 = fill, 0 = hit |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 2 | Way of the access |
| rep_req | input | 1 | Replacement request |
| rep_set | input | SET_W | Set index of the request |
| victim_valid | output | 1 | Victim is valid |
| victim_way | output | 2 | Way to evict |

## Verification
An access and a replacement request can land in the same cycle, and the two can name the same set or different sets. The stimulus table provokes this in every policy: a hit followed by a same-cycle request in LRU mode, a fill raced against a request in FIFO mode, a hit on the last untouched way in LFU mode, and an access to one set while another set is requested. When the sets match, the expected victim is the one implied by the state after the access. When the sets differ, the expected victim is the requested set's own untouched answer, so a selector that reads stale state, or the wrong set's state, returns a different way.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    localparam int NUM_WAYS = 4;
    localparam int WAY_W    = $clog2(NUM_WAYS);
    localparam int CNT_W    = 3;
    localparam int LFSR_W   = 16;

    typedef enum logic [2:0] {
        POL_LRU2  = 3'd0,
        POL_PLRU4 = 3'd1,
        POL_FIFO  = 3'd2,
        POL_LFU   = 3'd3,
        POL_RAND  = 3'd4
    } policy_e;

    typedef struct packed {
        logic [1:0]                       use_bits;
        logic                             tree_root;
        logic [1:0]                       tree_pair;
        logic [WAY_W-1:0]                 fifo_ptr;
        logic [NUM_WAYS-1:0][CNT_W-1:0]   cnt;
    } repl_state_t;

    function automatic repl_state_t apply_access(
        input repl_state_t     s,
        input logic [WAY_W-1:0] w,
        input logic            fill
    );
        repl_state_t r;
        r = s;
        if (!w[1]) begin
            r.use_bits = w[0] ? 2'b10 : 2'b01;
        end
        r.tree_root        = ~w[1];
        r.tree_pair[w[1]]  = ~w[0];
        if (fill) begin
            r.fifo_ptr = s.fifo_ptr + 1'b1;
            r.cnt[w]   = CNT_W'(1);
        end else if (s.cnt[w] != {CNT_W{1'b1}}) begin
            r.cnt[w] = s.cnt[w] + 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/vsel_lfsr.sv
module vsel_lfsr
    import vsel_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WAY_W-1:0] rand_way
);
    logic [LFSR_W-1:0] lfsr_q;
    logic              feedback;

    assign feedback = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= {lfsr_q[LFSR_W-2:0], feedback};
        end
    end

    assign rand_way = lfsr_q[WAY_W-1:0];

    // R7: the shift register never locks up in the all-zero state
    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

endmodule

// File: rtl/vsel_set_state.sv
module vsel_set_state
    import vsel_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_fill,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic [SET_W-1:0] rep_set,
    output repl_state_t      rep_view
);
    repl_state_t table_q [NUM_SETS];
    repl_state_t acc_next;

    assign acc_next = apply_access(table_q[acc_set], acc_way, acc_fill);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SETS; i++) begin
                table_q[i] <= '0;
            end
        end else if (acc_valid) begin
            table_q[acc_set] <= acc_next;
        end
    end

    // same-set access forwarded so the victim sees the post-access state
    always_comb begin
        if (acc_valid && (acc_set == rep_set)) begin
            rep_view = acc_next;
        end else begin
            rep_view = table_q[rep_set];
        end
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set_chk
        // R5: a set's FIFO pointer only moves on a fill to that set
        a_r5_ptr_fill_only: assert property (@(posedge clk) disable iff (rst)
            !(acc_valid && acc_fill && (acc_set == SET_W'(s)))
            |=> $stable(table_q[s].fifo_ptr));
        // R6: after a hit the referenced line's count is nonzero
        a_r6_hit_counts: assert property (@(posedge clk) disable iff (rst)
            (acc_valid && !acc_fill && (acc_set == SET_W'(s)))
            |=> table_q[s].cnt[$past(acc_way)] != '0);
        // R10: a set untouched by any access keeps all of its state
        a_r10_set_isolated: assert property (@(posedge clk) disable iff (rst)
            !(acc_valid && (acc_set == SET_W'(s)))
            |=> $stable(table_q[s]));
    end

endmodule

// File: rtl/vsel_pick.sv
module vsel_pick
    import vsel_pkg::*;
(
    input  logic [2:0]       policy_sel,
    input  repl_state_t      st,
    input  logic [WAY_W-1:0] rand_way,
    output logic [WAY_W-1:0] way
);
    logic [WAY_W-1:0] lfu_way;

    always_comb begin
        lfu_way = '0;
        for (int i = 1; i < NUM_WAYS; i++) begin
            if (st.cnt[i] < st.cnt[lfu_way]) begin
                lfu_way = WAY_W'(i);
            end
        end
    end

    always_comb begin
        case (policy_sel)
            POL_LRU2:  way = st.use_bits[0] ? WAY_W'(1) : WAY_W'(0);
            POL_PLRU4: way = {st.tree_root, st.tree_pair[st.tree_root]};
            POL_FIFO:  way = st.fifo_ptr;
            POL_LFU:   way = lfu_way;
            POL_RAND:  way = rand_way;
            default:   way = '0;
        endcase
    end

endmodule

// File: rtl/vsel_ctrl.sv
module vsel_ctrl
    import vsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rep_req,
    input  logic [WAY_W-1:0] way_d,
    output logic             victim_valid,
    output logic [WAY_W-1:0] victim_way
);
    typedef enum logic {
        CTRL_IDLE   = 1'b0,
        CTRL_REPORT = 1'b1
    } ctrl_e;

    ctrl_e            state_q, state_d;
    logic [WAY_W-1:0] way_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTRL_IDLE:   if (rep_req)  state_d = CTRL_REPORT;
            CTRL_REPORT: if (!rep_req) state_d = CTRL_IDLE;
            default:     state_d = CTRL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTRL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            way_q <= '0;
        end else if (rep_req) begin
            way_q <= way_d;
        end
    end

    always_comb begin
        victim_valid = (state_q == CTRL_REPORT);
        victim_way   = way_q;
    end

    // R1: a request is answered on the following cycle
    a_r1_valid_after_req: assert property (@(posedge clk) disable iff (rst)
        rep_req |=> victim_valid);
    // R1: no answer without a request
    a_r1_no_stale_valid: assert property (@(posedge clk) disable iff (rst)
        !rep_req |=> !victim_valid);

endmodule

// File: rtl/victim_selector.sv
module victim_selector
    import vsel_pkg::*;
#(
    parameter int NUM_SETS          = 16,
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    localparam int SET_W            = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       policy_sel,
    input  logic             acc_valid,
    input  logic             acc_fill,
    input  logic [SET_W-1:0] acc_set,
    input  logic [1:0]       acc_way,
    input  logic             rep_req,
    input  logic [SET_W-1:0] rep_set,
    output logic             victim_valid,
    output logic [1:0]       victim_way
);
    repl_state_t      rep_view;
    logic [WAY_W-1:0] rand_way;
    logic [WAY_W-1:0] pick_way;

    vsel_set_state #(.NUM_SETS(NUM_SETS)) u_state (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_fill  (acc_fill),
        .acc_set   (acc_set),
        .acc_way   (acc_way),
        .rep_set   (rep_set),
        .rep_view  (rep_view)
    );

    vsel_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .rand_way (rand_way)
    );

    vsel_pick u_pick (
        .policy_sel (policy_sel),
        .st         (rep_view),
        .rand_way   (rand_way),
        .way        (pick_way)
    );

    vsel_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .rep_req      (rep_req),
        .way_d        (pick_way),
        .victim_valid (victim_valid),
        .victim_way   (victim_way)
    );

    // R3: two-way LRU only ever names way 0 or way 1
    a_r3_lru2_low_pair: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && ($past(policy_sel) == POL_LRU2)) |-> (victim_way < 2'd2));
    // R2: unassigned policy codes answer way 0
    a_r2_unknown_way0: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && ($past(policy_sel) > 3'd4)) |-> (victim_way == 2'd0));

endmodule

// File: tb/victim_selector_test.sv
module victim_selector_test;
    localparam int NSETS = 16;
    localparam int NVEC  = 34;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] policy_sel = '0;
    logic       acc_valid = 1'b0, acc_fill = 1'b0;
    logic [3:0] acc_set = '0, rep_set = '0;
    logic [1:0] acc_way = '0;
    logic       rep_req = 1'b0;
    logic       victim_valid;
    logic [1:0] victim_way;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    victim_selector #(.NUM_SETS(NSETS)) uut (
        .clk(clk), .rst(rst), .policy_sel(policy_sel),
        .acc_valid(acc_valid), .acc_fill(acc_fill), .acc_set(acc_set),
        .acc_way(acc_way), .rep_req(rep_req), .rep_set(rep_set),
        .victim_valid(victim_valid), .victim_way(victim_way)
    );

    // reference LFSR built from R7
    logic [15:0] ref_lfsr;
    logic [1:0]  exp_rand;
    always @(posedge clk) begin
        if (rst) ref_lfsr <= 16'hACE1;
        else     ref_lfsr <= {ref_lfsr[14:0], ref_lfsr[15] ^ ref_lfsr[13] ^ ref_lfsr[12] ^ ref_lfsr[10]};
        if (rep_req) exp_rand <= ref_lfsr[1:0];
    end

    // {policy, acc_valid, fill, acc_set, acc_way, rep_req, rep_set, expected way}
    localparam logic [17:0] VEC [NVEC] = '{
        {3'd0,1'b1,1'b0,4'd1,2'd0,1'b1,4'd1,2'd1}, // R3 R9 hit w0 + req
        {3'd0,1'b0,1'b0,4'd0,2'd0,1'b1,4'd1,2'd1}, // R3
        {3'd0,1'b1,1'b0,4'd1,2'd1,1'b0,4'd0,2'd0}, // R3 hit w1
        {3'd0,1'b0,1'b0,4'd0,2'd0,1'b1,4'd1,2'd0}, // R3
        {3'd0,1'b1,1'b0,4'd1,2'd3,1'b0,4'd0,2'd0}, // R3 hit w3 ignored
        {3'd0,1'b0,1'b0,4'd0,2'd0,1'b1,4'd1,2'd0}, // R3
        {3'd0,1'b0,1'b0,4'd0,2'd0,1'b1,4'd2,2'd0}, // R10 fresh set
        {3'd1,1'b1,1'b0,4'd3,2'd0,1'b0,4'd0,2'd0}, // R4 hit w0
        {3'd1,1'b0,1'b0,4'd0,2'd0,1'b1,4'd3,2'd2}, // R4
        {3'd1,1'b1,1'b0,4'd3,2'd2,1'b0,4'd0,2'd0}, // R4 hit w2
        {3'd1,1'b0,1'b0,4'd0,2'd0,1'b1,4'd3,2'd1}, // R4
        {3'd1,1'b1,1'b0,4'd3,2'd1,1'b1,4'd3,2'd3}, // R4 R9 hit w1 + req
        {3'd1,1'b1,1'b0,4'd3,2'd3,1'b0,4'd0,2'd0}, // R4 hit w3
        {3'd1,1'b0,1'b0,4'd0,2'd0,1'b1,4'd3,2'd0}, // R4
        {3'd2,1'b0,1'b0,4'd0,2'd0,1'b1,4'd4,2'd0}, // R5
        {3'd2,1'b1,1'b1,4'd4,2'd0,1'b0,4'd0,2'd0}, // R5 fill
        {3'd2,1'b1,1'b0,4'd4,2'd1,1'b1,4'd4,2'd1}, // R5 hit does not move
        {3'd2,1'b1,1'b1,4'd4,2'd1,1'b1,4'd4,2'd2}, // R5 R9 fill + req
        {3'd2,1'b1,1'b1,4'd4,2'd2,1'b0,4'd0,2'd0}, // R5
        {3'd2,1'b1,1'b1,4'd4,2'd3,1'b0,4'd0,2'd0}, // R5 wrap
        {3'd2,1'b0,1'b0,4'd0,2'd0,1'b1,4'd4,2'd0}, // R5
        {3'd3,1'b1,1'b0,4'd5,2'd0,1'b0,4'd0,2'd0}, // R6
        {3'd3,1'b0,1'b0,4'd0,2'd0,1'b1,4'd5,2'd1}, // R6
        {3'd3,1'b1,1'b0,4'd5,2'd1,1'b0,4'd0,2'd0}, // R6
        {3'd3,1'b1,1'b0,4'd5,2'd2,1'b0,4'd0,2'd0}, // R6
        {3'd3,1'b1,1'b0,4'd5,2'd3,1'b1,4'd5,2'd0}, // R6 R9 tie -> lowest
        {3'd3,1'b1,1'b0,4'd5,2'd0,1'b1,4'd5,2'd1}, // R6
        {3'd3,1'b1,1'b1,4'd5,2'd0,1'b1,4'd5,2'd0}, // R6 fill sets count 1
        {3'd3,1'b0,1'b0,4'd0,2'd0,1'b1,4'd1,2'd2}, // R11 LFU on set 1
        {3'd2,1'b0,1'b0,4'd0,2'd0,1'b1,4'd5,2'd1}, // R11 FIFO on set 5
        {3'd5,1'b0,1'b0,4'd0,2'd0,1'b1,4'd5,2'd0}, // R2
        {3'd7,1'b0,1'b0,4'd0,2'd0,1'b1,4'd1,2'd0}, // R2
        {3'd0,1'b1,1'b0,4'd6,2'd0,1'b1,4'd7,2'd0}, // R10 R9 other set
        {3'd0,1'b0,1'b0,4'd0,2'd0,1'b1,4'd6,2'd1}  // R10
    };

    function automatic string tag_of(input int i);
        if (i < 6)  return "R3";
        if (i == 6) return "R10";
        if (i < 14) return "R4";
        if (i < 21) return "R5";
        if (i < 28) return "R6";
        if (i < 30) return "R11";
        if (i < 32) return "R2";
        return "R10";
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        acc_valid = 1'b0; acc_fill = 1'b0; rep_req = 1'b0;
    endtask

    task automatic ask(input logic [2:0] pol, input logic [3:0] s, input logic [1:0] exp, input string tag);
        policy_sel = pol; rep_set = s; rep_req = 1'b1; acc_valid = 1'b0;
        @(negedge clk);
        chk({tag, " valid"}, {3'b0, victim_valid}, 4'd1);
        chk(tag, {2'b0, victim_way}, {2'b0, exp});
        rep_req = 1'b0;
    endtask

    task automatic hit(input logic [3:0] s, input logic [1:0] w);
        acc_valid = 1'b1; acc_fill = 1'b0; acc_set = s; acc_way = w; rep_req = 1'b0;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset valid", {3'b0, victim_valid}, 4'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            policy_sel = VEC[i][17:15];
            acc_valid  = VEC[i][14];
            acc_fill   = VEC[i][13];
            acc_set    = VEC[i][12:9];
            acc_way    = VEC[i][8:7];
            rep_req    = VEC[i][6];
            rep_set    = VEC[i][5:2];
            @(negedge clk);
            chk({tag_of(i), " valid"}, {3'b0, victim_valid}, {3'b0, VEC[i][6]});
            if (VEC[i][6]) chk(tag_of(i), {2'b0, victim_way}, {2'b0, VEC[i][1:0]});
        end
        idle_inputs();
        @(negedge clk);

        // R8: reset wipes state that was non-zero
        rst = 1'b1;
        @(negedge clk);
        chk("R8 valid low in reset", {3'b0, victim_valid}, 4'd0);
        rst = 1'b0;
        ask(3'd0, 4'd6, 2'd0, "R8 lru2");
        ask(3'd1, 4'd5, 2'd0, "R8 plru");
        ask(3'd2, 4'd5, 2'd0, "R8 fifo");
        ask(3'd3, 4'd1, 2'd0, "R8 lfu");

        // R6: saturation at 7 on set 8
        for (int k = 0; k < 6; k++) hit(4'd8, 2'd0);
        for (int k = 0; k < 8; k++) hit(4'd8, 2'd1);
        for (int k = 0; k < 7; k++) hit(4'd8, 2'd2);
        for (int k = 0; k < 7; k++) hit(4'd8, 2'd3);
        ask(3'd3, 4'd8, 2'd0, "R6 saturate");

        // R7 R1: back-to-back random requests
        policy_sel = 3'd4; rep_req = 1'b1;
        for (int k = 0; k < 24; k++) begin
            rep_set = 4'(k);
            acc_valid = k[0]; acc_set = 4'(k); acc_way = 2'(k);
            @(negedge clk);
            chk("R1 back-to-back valid", {3'b0, victim_valid}, 4'd1);
            chk("R7 random", {2'b0, victim_way}, {2'b0, exp_rand});
        end
        idle_inputs();
        @(negedge clk);
        chk("R1 valid drops", {3'b0, victim_valid}, 4'd0);

        finish_run();
    end

endmodule